// File: doc/BRIEF.md
# Questionable Status Group with Edge Filters

This block holds one questionable-status group for an instrument's status model. A parallel vector of live status flags is sampled every clock into a condition register. The condition register is read-only and does not latch. Two per-bit filter masks pick which edges of each condition bit are recorded. The rising mask lets a 0-to-1 change through, and the falling mask lets a 1-to-0 change through. Each recorded edge sets a sticky bit in an event register. An enable mask selects which event bits take part in a single summary flag. That flag is meant to drive bit 3 of the status byte.

Software reaches the block through a simple synchronous register port with a select, a write strobe, a read strobe and registered read data. Reading the event register clears it. A separate clear strobe, standing in for the clear-status command, also clears it. Loading a filter mask can raise events by itself. A newly armed rising filter bit records an event when its condition is already high. A newly armed falling filter bit records an event when its condition is already low.

Top module: `sreg_ques_group`

## Requirements
- R1: Synchronous active-high reset clears the event register, the enable mask, both filter masks and the summary output. A read of any of these registers after reset returns 0.
- R2: A read with select 0 returns the condition register. The condition register equals `stat_in` as sampled on the previous clock edge.
- R3: When rising-filter bit i (select 3) is 1, a 0-to-1 change of condition bit i sets event bit i.
- R4: When falling-filter bit i (select 4) is 1, a 1-to-0 change of condition bit i sets event bit i. With only that filter set, a rising change of bit i is ignored.
- R5: When both filter bits of a position are 1, either change of that condition bit sets its event bit. When both are 0, no change of that bit sets it.
- R6: Event bits are sticky and stay set until cleared, whatever the condition does afterwards.
- R7: A read with select 1 returns the event register and clears it on the same clock edge. An event bit that is set on that same edge stays set.
- R8: A one-cycle `clr_all` pulse zeroes the event register and leaves the enable mask and both filter masks unchanged.
- R9: `summary` is registered. It equals the OR of (event AND enable) as they stood one clock earlier.
- R10: The enable mask (select 2) can be written and read back. Its top bit always reads as 0, so 16'hFFFF reads back as 16'h7FFF.
- R11: A write to the rising filter sets event bit i for every bit i that goes from 0 to 1 in the mask while condition bit i is 1. Bits that were already set raise nothing.
- R12: A write to the falling filter sets event bit i for every bit i that goes from 0 to 1 in the mask while condition bit i is 0.
- R13: A read with select 5, 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_in | input | 16 | Live status flags |
| reg_sel | input | 3 | Register select: 0 condition, 1 event, 2 enable, 3 rising filter, 4 falling filter |
| wr_stb | input | 1 | Write strobe for the enable and filter registers |
| wr_data | input | 16 | Write data |
| rd_stb | input | 1 | Read strobe; `rd_data` updates on the next edge |
| clr_all | input | 1 | Clear-status strobe for the event register |
| rd_data | output | 16 | Registered read data, held between reads |
| summary | output | 1 | Registered OR of the enabled event bits |

## Verification
The hardest case to reach from the ports is a read that clears the event register on exactly the edge where a new event lands. The edge can come from a condition change or from a filter write. The directed part of the bench makes this happen by changing `stat_in` one cycle before it issues an event read. Filter-write events are set up by first holding a condition bit high or low and then arming its filter bit. The random part mixes reads, writes, clear pulses and single-bit status toggles in the same cycles. A cycle model compares every read and every summary value against its own prediction.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_COND   = 3'd0,
    SEL_EVENT  = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_RISE   = 3'd3,
    SEL_FALL   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/sreg_cond_sampler.sv
module sreg_cond_sampler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_in,
  output logic [W-1:0] cond_q,
  output logic [W-1:0] prev_q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      prev_q <= '0;
    end else begin
      cond_q <= stat_in;
      prev_q <= cond_q;
    end
  end

  // per-bit edge detection against the previous sample
  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise[i] = cond_q[i] & ~prev_q[i];
    assign fall[i] = ~cond_q[i] & prev_q[i];
  end
endmodule

// File: rtl/sreg_filter_regs.sv
module sreg_filter_regs
  import sreg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cond_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] rise_mask_q,
  output logic [W-1:0] fall_mask_q,
  output logic [W-1:0] wr_set
);
  localparam logic [W-1:0] EN_KEEP = {1'b0, {(W-1){1'b1}}};

  logic wr_en_reg, wr_rise, wr_fall;

  assign wr_en_reg = wr_stb && (sel == SEL_ENABLE);
  assign wr_rise   = wr_stb && (sel == SEL_RISE);
  assign wr_fall   = wr_stb && (sel == SEL_FALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= '0;
      rise_mask_q <= '0;
      fall_mask_q <= '0;
    end else begin
      if (wr_en_reg) en_q        <= wr_data & EN_KEEP;
      if (wr_rise)   rise_mask_q <= wr_data;
      if (wr_fall)   fall_mask_q <= wr_data;
    end
  end

  // newly armed filter bits that already see their level raise an event
  logic [W-1:0] arm_rise, arm_fall;
  assign arm_rise = wr_rise ? (wr_data & ~rise_mask_q & cond_q)  : '0;
  assign arm_fall = wr_fall ? (wr_data & ~fall_mask_q & ~cond_q) : '0;
  assign wr_set   = arm_rise | arm_fall;
endmodule

// File: rtl/sreg_event_latch.sv
module sreg_event_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr,
  output logic [W-1:0] evt_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             evt_q[i] <= 1'b0;
      else if (set_vec[i]) evt_q[i] <= 1'b1;
      else if (clr)        evt_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sreg_ques_group.sv
module sreg_ques_group
  import sreg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     stat_in,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             wr_stb,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_stb,
  input  logic             clr_all,
  output logic [W-1:0]     rd_data,
  output logic             summary
);
  reg_sel_e     sel;
  logic [W-1:0] cond_q, prev_q, rise, fall;
  logic [W-1:0] en_q, rise_mask_q, fall_mask_q, wr_set;
  logic [W-1:0] set_vec, evt_q;
  logic         evt_clr;

  assign sel = reg_sel_e'(reg_sel);

  sreg_cond_sampler #(.W(W)) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .stat_in(stat_in),
    .cond_q (cond_q),
    .prev_q (prev_q),
    .rise   (rise),
    .fall   (fall)
  );

  sreg_filter_regs #(.W(W)) u_filters (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .sel        (sel),
    .wr_data    (wr_data),
    .cond_q     (cond_q),
    .en_q       (en_q),
    .rise_mask_q(rise_mask_q),
    .fall_mask_q(fall_mask_q),
    .wr_set     (wr_set)
  );

  assign set_vec = (rise & rise_mask_q) | (fall & fall_mask_q) | wr_set;
  assign evt_clr = clr_all || (rd_stb && (sel == SEL_EVENT));

  sreg_event_latch #(.W(W)) u_events (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .clr    (evt_clr),
    .evt_q  (evt_q)
  );

  logic [W-1:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_COND:   rd_mux = cond_q;
      SEL_EVENT:  rd_mux = evt_q;
      SEL_ENABLE: rd_mux = en_q;
      SEL_RISE:   rd_mux = rise_mask_q;
      SEL_FALL:   rd_mux = fall_mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      summary <= 1'b0;
    end else begin
      if (rd_stb) rd_data <= rd_mux;
      summary <= |(evt_q & en_q);
    end
  end
endmodule

// File: rtl/sreg_ques_group_chk.sv
module sreg_ques_group_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] stat_in,
  input logic [W-1:0] cond_q,
  input logic [W-1:0] prev_q,
  input logic [W-1:0] rise_mask_q,
  input logic [W-1:0] fall_mask_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] evt_q,
  input logic [W-1:0] set_vec,
  input logic         evt_clr,
  input logic         summary
);
  AST_COND_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cond_q == $past(stat_in)); // R2

  AST_RISE_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (|(cond_q & ~prev_q & rise_mask_q)) |=>
      ((evt_q & $past(cond_q & ~prev_q & rise_mask_q)) == $past(cond_q & ~prev_q & rise_mask_q))); // R3

  AST_FALL_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (|(~cond_q & prev_q & fall_mask_q)) |=>
      ((evt_q & $past(~cond_q & prev_q & fall_mask_q)) == $past(~cond_q & prev_q & fall_mask_q))); // R4

  AST_EVENTS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !evt_clr |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R6

  AST_CLEAR_KEEPS_SETS: assert property (@(posedge clk) disable iff (rst)
    evt_clr |=> evt_q == $past(set_vec)); // R8

  AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
    !rst |=> summary == $past(|(evt_q & en_q))); // R9
endmodule

bind sreg_ques_group sreg_ques_group_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_in    (stat_in),
  .cond_q     (cond_q),
  .prev_q     (prev_q),
  .rise_mask_q(rise_mask_q),
  .fall_mask_q(fall_mask_q),
  .en_q       (en_q),
  .evt_q      (evt_q),
  .set_vec    (set_vec),
  .evt_clr    (evt_clr),
  .summary    (summary)
);

// File: tb/sreg_ques_group_bench.sv
module sreg_ques_group_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] stat_in = '0;
  logic [2:0]  reg_sel = '0;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_stb = 1'b0;
  logic        clr_all = 1'b0;
  logic [15:0] rd_data;
  logic        summary;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sreg_ques_group u_sreg_ques_group (
    .clk    (clk),
    .rst    (rst),
    .stat_in(stat_in),
    .reg_sel(reg_sel),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .rd_stb (rd_stb),
    .clr_all(clr_all),
    .rd_data(rd_data),
    .summary(summary)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  logic [15:0] m_cond, m_prev, m_evt, m_en, m_rise, m_fall, m_rd;
  logic        m_sum, m_rd_last;
  logic [2:0]  m_rd_sel;

  function automatic logic [15:0] sel_val(input logic [2:0] s, input logic [15:0] c,
      input logic [15:0] e, input logic [15:0] en, input logic [15:0] r, input logic [15:0] f);
    case (s)
      3'd0: return c;
      3'd1: return e;
      3'd2: return en;
      3'd3: return r;
      3'd4: return f;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string sel_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R7";
      3'd2: return "R10";
      3'd3: return "R11";
      3'd4: return "R12";
      default: return "R13";
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [15:0] s;
    if (rst) begin
      m_cond = '0; m_prev = '0; m_evt = '0; m_en = '0;
      m_rise = '0; m_fall = '0; m_rd = '0; m_sum = 1'b0;
      m_rd_last = 1'b0; m_rd_sel = '0;
    end else begin
      s = (m_cond & ~m_prev & m_rise) | (~m_cond & m_prev & m_fall);
      if (wr_stb && reg_sel == 3'd3) s = s | (wr_data & ~m_rise & m_cond);
      if (wr_stb && reg_sel == 3'd4) s = s | (wr_data & ~m_fall & ~m_cond);
      if (rd_stb) m_rd = sel_val(reg_sel, m_cond, m_evt, m_en, m_rise, m_fall);
      m_rd_last = rd_stb;
      m_rd_sel  = reg_sel;
      m_sum = |(m_evt & m_en);
      if (clr_all || (rd_stb && reg_sel == 3'd1)) m_evt = '0;
      m_evt = m_evt | s;
      if (wr_stb && reg_sel == 3'd2) m_en = wr_data & 16'h7FFF;
      if (wr_stb && reg_sel == 3'd3) m_rise = wr_data;
      if (wr_stb && reg_sel == 3'd4) m_fall = wr_data;
      m_prev = m_cond;
      m_cond = stat_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9", {15'd0, summary}, {15'd0, m_sum});
      if (m_rd_last) chk(sel_tag(m_rd_sel), rd_data, m_rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; reg_sel = s; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] s, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_stb = 1'b1; reg_sel = s;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", {15'd0, summary}, 16'h0000);
    rd_exp(3'd1, 16'h0000, "R1");
    rd_exp(3'd2, 16'h0000, "R1");
    rd_exp(3'd3, 16'h0000, "R1");
    rd_exp(3'd4, 16'h0000, "R1");
    rd_exp(3'd6, 16'h0000, "R13");

    wr(3'd2, 16'hFFFF);
    rd_exp(3'd2, 16'h7FFF, "R10");

    wr(3'd3, 16'h0005);
    wr(3'd4, 16'h0006);              // bits 1,2 armed while low
    rd_exp(3'd1, 16'h0006, "R12");
    rd_exp(3'd1, 16'h0000, "R7");

    stat_in = 16'h0001; idle(3);
    rd_exp(3'd1, 16'h0001, "R3");
    rd_exp(3'd0, 16'h0001, "R2");

    stat_in = 16'h0003; idle(3);
    rd_exp(3'd1, 16'h0000, "R4");
    stat_in = 16'h0001; idle(3);
    rd_exp(3'd1, 16'h0002, "R4");

    stat_in = 16'h0005; idle(3);
    rd_exp(3'd1, 16'h0004, "R5");
    stat_in = 16'h0001; idle(3);
    rd_exp(3'd1, 16'h0004, "R5");
    stat_in = 16'h0009; idle(3);
    stat_in = 16'h0001; idle(3);
    rd_exp(3'd1, 16'h0000, "R5");

    stat_in = 16'h0000; idle(3);
    stat_in = 16'h0001; idle(3);
    stat_in = 16'h0000; idle(8);
    rd_exp(3'd1, 16'h0001, "R6");

    stat_in = 16'h0004; idle(3);
    clear_pulse();
    rd_exp(3'd1, 16'h0000, "R8");
    rd_exp(3'd2, 16'h7FFF, "R8");
    rd_exp(3'd3, 16'h0005, "R8");
    rd_exp(3'd4, 16'h0006, "R8");

    stat_in = 16'h0044; idle(3);
    rd_exp(3'd1, 16'h0000, "R5");
    wr(3'd3, 16'h0045);
    rd_exp(3'd1, 16'h0040, "R11");
    wr(3'd3, 16'h0045);
    rd_exp(3'd1, 16'h0000, "R11");

    wr(3'd2, 16'h0000);
    stat_in = 16'h0040; idle(3);
    chk("R9", {15'd0, summary}, 16'h0000);
    wr(3'd2, 16'h0004); idle(2);
    chk("R9", {15'd0, summary}, 16'h0001);
    wr(3'd2, 16'h0001); idle(2);
    chk("R9", {15'd0, summary}, 16'h0000);

    clear_pulse();
    stat_in = 16'h0044;              // rise lands on the read's edge
    rd_exp(3'd1, 16'h0000, "R7");
    rd_exp(3'd1, 16'h0004, "R7");

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_stb  = ($urandom % 5) == 0;
      rd_stb  = ($urandom % 3) == 0;
      clr_all = ($urandom % 23) == 0;
      reg_sel = 3'($urandom % 8);
      wr_data = 16'($urandom);
      if (($urandom % 3) == 0) stat_in = stat_in ^ (16'h0001 << ($urandom % 16));
      if (($urandom % 97) == 0) stat_in = 16'($urandom);
    end
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; clr_all = 1'b0;
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule